// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiply Unit

This unit is the multiply path of a 64-bit execute stage. Each cycle it can accept one operation: two 65-bit operands that upstream logic has already sign- or zero-extended, a result selector, a 5-bit destination register number and a record flag. It always multiplies the two operands as signed 65-bit numbers. Signed and unsigned forms are therefore both covered by the choice of the 65th bit. The 32-bit and immediate forms work the same way, because the caller places the narrow value in the low bits and extends it through the whole 65 bits.

After a fixed number of cycles set by a parameter, the unit presents one of three results for register writeback: the low doubleword, the high doubleword, or the high word of a 32x32 product. It also presents the destination number and a write enable. When the record flag is set, it also presents a 32-bit condition value whose top nibble classifies the 64-bit result as negative, positive or zero.

The pipeline is fully pipelined. Every accepted operation keeps its own stage registers, so operations on consecutive cycles each return in order, with no bubbles between them.

Top module: `mul_unit`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge appears with `out_valid` high exactly `DEPTH` rising edges later (default 4). `out_valid` is low on every cycle that does not carry such a result.
- R2: The operands are multiplied as signed 65-bit values. With a zero in bit 64 the result equals the unsigned 64x64 product, and with the sign copied into bit 64 it equals the signed product.
- R3: Selector code 0 returns bits 63..0 of the product. Code 3 is reserved and behaves as code 0.
- R4: Selector code 1 returns bits 127..64 of the product.
- R5: Selector code 2 returns product bits 63..32 in both `out_data[31:0]` and `out_data[63:32]`. This is the high word of a 32x32 product whose operands were extended through bit 64.
- R6: `out_dest` equals the `in_dest` of the same operation, and `out_wr_en` is high exactly when `out_valid` is high.
- R7: `out_cr_en` is high only with `out_valid`, and only when the operation's `in_rec` was 1. When `in_rec` was 0, `out_cr_en` stays low.
- R8: With `out_cr_en` high, `out_cr[31:28]` is 4'h8 when bit 63 of `out_data` is set, 4'h2 when `out_data` is zero, and 4'h4 otherwise. `out_cr[27:0]` is zero. For example, a positive non-zero result gives 32'h40000000.
- R9: Valid operations on consecutive cycles each produce their own correct result on consecutive cycles, in issue order.
- R10: A synchronous active-high `rst` clears every valid bit. No output is valid in the cycle after a reset edge, and operations in flight at that edge never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_sel | input | 2 | Result selector: 0 low, 1 high, 2 high word, 3 as 0 |
| in_dest | input | 5 | Destination register number |
| in_rec | input | 1 | Request a condition value |
| in_a | input | 65 | First operand, pre-extended |
| in_b | input | 65 | Second operand, pre-extended |
| out_valid | output | 1 | Result present this cycle |
| out_wr_en | output | 1 | Register write enable |
| out_dest | output | 5 | Destination register number |
| out_data | output | 64 | Selected result |
| out_cr_en | output | 1 | Condition value write enable |
| out_cr | output | 32 | Condition value, class in bits 31..28 |

## Verification
The hardest situation to reach from the ports is a full pipeline of unrelated operations. In that state every stage holds a different selector, destination and record flag, and the valid-gated product registers must not mix neighbouring data. The bench reaches it with long runs of issues on consecutive cycles, and between those runs it mixes in random idle gaps so that stages sit idle and stale. The sign-sensitive corners are also covered: the most negative operand times minus one, zero operands, and the largest unsigned square. A reset is applied while operations are in flight, and the bench checks that none of them appears afterwards.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

    localparam int XLEN = 64;
    localparam int OPW  = XLEN + 1;
    localparam int PRW  = 2 * XLEN;
    localparam int REGW = 5;
    localparam int CRW  = 32;
    localparam int HALF = XLEN / 2;

    typedef enum logic [1:0] {
        SEL_LO  = 2'd0,
        SEL_HI  = 2'd1,
        SEL_HW  = 2'd2,
        SEL_RSV = 2'd3
    } msel_e;

    typedef struct packed {
        logic            vld;
        msel_e           sel;
        logic [REGW-1:0] dest;
        logic            rec;
    } mtag_t;

    // Choose the writeback value from the truncated product.
    function automatic logic [XLEN-1:0] pick_result(msel_e s, logic [PRW-1:0] p);
        logic [XLEN-1:0] r;
        case (s)
            SEL_HI:  r = p[PRW-1:XLEN];
            SEL_HW:  r = {p[XLEN-1:HALF], p[XLEN-1:HALF]};
            default: r = p[XLEN-1:0];
        endcase
        return r;
    endfunction

    // Classify a 64-bit result into the top nibble of the condition value.
    function automatic logic [CRW-1:0] classify(logic [XLEN-1:0] r);
        logic [3:0] f;
        if (r[XLEN-1])      f = 4'h8;
        else if (r == '0)   f = 4'h2;
        else                f = 4'h4;
        return {f, {(CRW-4){1'b0}}};
    endfunction

endpackage

// File: rtl/mul_tag_pipe.sv
module mul_tag_pipe
    import mulp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  mtag_t            tag_i,
    output logic [DEPTH-1:0] en_o,
    output mtag_t            tag_o
);

    mtag_t st [DEPTH];

    always_ff @(posedge clk) begin
        st[0] <= tag_i;
        if (rst) st[0].vld <= 1'b0;
    end

    assign en_o[0] = tag_i.vld;

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            st[i] <= st[i-1];
            if (rst) st[i].vld <= 1'b0;
        end
        assign en_o[i] = st[i-1].vld;

        // R1: a valid stage moves on one stage per cycle
        p_adv_r1: assert property (@(posedge clk) disable iff (rst)
            st[i-1].vld |=> st[i].vld);
        // R1: an empty stage stays empty as it moves
        p_bubble_r1: assert property (@(posedge clk) disable iff (rst)
            !st[i-1].vld |=> !st[i].vld);
        // R6: destination number carried unchanged
        p_dest_r6: assert property (@(posedge clk) disable iff (rst)
            st[i-1].vld |=> st[i].dest == $past(st[i-1].dest));
    end

    assign tag_o = st[DEPTH-1];

endmodule

// File: rtl/mul_prod_pipe.sv
module mul_prod_pipe
    import mulp_pkg::*;
#(
    parameter int DEPTH = 4   // at least 2: operand stage plus one product stage
) (
    input  logic             clk,
    input  logic [DEPTH-1:0] en,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [PRW-1:0]   prod
);

    localparam int EXTW = PRW - OPW;

    logic signed [PRW-1:0] ea, eb;
    logic [PRW-1:0] pr [1:DEPTH-1];

    // Operand stage: extend to product width so the low PRW bits are exact.
    always_ff @(posedge clk) begin
        if (en[0]) begin
            ea <= {{EXTW{a[OPW-1]}}, a};
            eb <= {{EXTW{b[OPW-1]}}, b};
        end
    end

    always_ff @(posedge clk) begin
        if (en[1]) pr[1] <= ea * eb;
    end

    for (genvar i = 2; i < DEPTH; i++) begin : g_delay
        always_ff @(posedge clk) begin
            if (en[i]) pr[i] <= pr[i-1];
        end
    end

    assign prod = pr[DEPTH-1];

endmodule

// File: rtl/mul_finish.sv
module mul_finish
    import mulp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  mtag_t            tag,
    input  logic [PRW-1:0]   prod,
    output logic             valid,
    output logic [REGW-1:0]  dest,
    output logic [XLEN-1:0]  data,
    output logic             cr_en,
    output logic [CRW-1:0]   cr
);

    logic [XLEN-1:0] res;

    always_comb begin
        res   = pick_result(tag.sel, prod);
        valid = tag.vld;
        dest  = tag.dest;
        data  = res;
        cr_en = tag.vld & tag.rec;
        cr    = tag.rec ? classify(res) : '0;
    end

endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mulp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_sel,
    input  logic [REGW-1:0]  in_dest,
    input  logic             in_rec,
    input  logic [OPW-1:0]   in_a,
    input  logic [OPW-1:0]   in_b,
    output logic             out_valid,
    output logic             out_wr_en,
    output logic [REGW-1:0]  out_dest,
    output logic [XLEN-1:0]  out_data,
    output logic             out_cr_en,
    output logic [CRW-1:0]   out_cr
);

    mtag_t            tag_in, tag_last;
    logic [DEPTH-1:0] stage_en;
    logic [PRW-1:0]   prod_last;

    assign tag_in = '{vld: in_valid, sel: msel_e'(in_sel), dest: in_dest, rec: in_rec};

    mul_tag_pipe #(.DEPTH(DEPTH)) u_tags (
        .clk   (clk),
        .rst   (rst),
        .tag_i (tag_in),
        .en_o  (stage_en),
        .tag_o (tag_last)
    );

    mul_prod_pipe #(.DEPTH(DEPTH)) u_prod (
        .clk  (clk),
        .en   (stage_en),
        .a    (in_a),
        .b    (in_b),
        .prod (prod_last)
    );

    mul_finish #(.DEPTH(DEPTH)) u_fin (
        .tag   (tag_last),
        .prod  (prod_last),
        .valid (out_valid),
        .dest  (out_dest),
        .data  (out_data),
        .cr_en (out_cr_en),
        .cr    (out_cr)
    );

    assign out_wr_en = out_valid;

    // R10: reset edge leaves no valid output behind it
    p_rst_clear_r10: assert property (@(posedge clk) rst |=> !out_valid);
    // R7: condition enable never without a valid result
    p_cr_gate_r7: assert property (@(posedge clk) disable iff (rst)
        out_cr_en |-> out_valid);
    // R8: exactly one class bit, rest of the condition value zero
    p_cr_fmt_r8: assert property (@(posedge clk) disable iff (rst)
        out_cr_en |-> (out_cr[CRW-5:0] == '0 && $countones(out_cr[CRW-1:CRW-4]) == 1));
    // R8: negative class follows the result sign bit
    p_cr_sign_r8: assert property (@(posedge clk) disable iff (rst)
        out_cr_en |-> (out_cr[CRW-1] == out_data[XLEN-1]));

endmodule

// File: tb/sim_mul_unit.sv
module sim_mul_unit;
    import mulp_pkg::*;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst;
    logic             in_valid;
    logic [1:0]       in_sel;
    logic [4:0]       in_dest;
    logic             in_rec;
    logic [64:0]      in_a, in_b;
    logic             out_valid, out_wr_en, out_cr_en;
    logic [4:0]       out_dest;
    logic [63:0]      out_data;
    logic [31:0]      out_cr;

    mul_unit #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
        .in_dest(in_dest), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_wr_en(out_wr_en), .out_dest(out_dest),
        .out_data(out_data), .out_cr_en(out_cr_en), .out_cr(out_cr)
    );

    typedef struct {
        int          due;
        logic [63:0] data;
        logic [4:0]  dest;
        logic        rec;
        logic [31:0] cr;
        string       req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_res(int sel, logic [64:0] a, logic [64:0] b);
        logic signed [129:0] sa, sb, p;
        sa = $signed(a);
        sb = $signed(b);
        p  = sa * sb;
        case (sel)
            1:       return p[127:64];
            2:       return {p[63:32], p[63:32]};
            default: return p[63:0];
        endcase
    endfunction

    function automatic logic [31:0] ref_cr(logic [63:0] r);
        if (r[63])        return 32'h8000_0000;
        else if (r == 0)  return 32'h2000_0000;
        else              return 32'h4000_0000;
    endfunction

    function automatic logic [64:0] sx64(logic [63:0] x); return {x[63], x}; endfunction
    function automatic logic [64:0] zx64(logic [63:0] x); return {1'b0, x}; endfunction
    function automatic logic [64:0] sx32(logic [31:0] x); return {{33{x[31]}}, x}; endfunction
    function automatic logic [64:0] zx32(logic [31:0] x); return {33'b0, x}; endfunction
    function automatic logic [64:0] sx16(logic [15:0] x); return {{49{x[15]}}, x}; endfunction
    function automatic logic [63:0] rnd64(); return {$urandom, $urandom}; endfunction

    // Per-cycle comparison against the expected queue.
    always begin
        @(posedge clk);
        cyc++;
        #3;
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk("R1 valid", 64'(out_valid), 64'd1);
                chk("R6 wr_en", 64'(out_wr_en), 64'd1);
                chk("R6 dest", 64'(out_dest), 64'(e.dest));
                chk(e.req, out_data, e.data);
                chk("R7 cr_en", 64'(out_cr_en), 64'(e.rec));
                if (e.rec) chk("R8 cr", 64'(out_cr), 64'(e.cr));
            end else begin
                chk("R1 idle valid", 64'(out_valid), 64'd0);
                chk("R6 idle wr_en", 64'(out_wr_en), 64'd0);
                chk("R7 idle cr_en", 64'(out_cr_en), 64'd0);
            end
        end
    end

    task automatic send(int sel, logic [64:0] a, logic [64:0] b, logic rec, string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_sel   = 2'(sel);
        in_dest  = 5'($urandom);
        in_rec   = rec;
        in_a     = a;
        in_b     = b;
        e.due  = cyc + DEPTH;
        e.data = ref_res(sel, a, b);
        e.dest = in_dest;
        e.rec  = rec;
        e.cr   = ref_cr(e.data);
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a     = 65'($urandom);
        end
    endtask

    function automatic string sel_req(int sel);
        case (sel)
            1:       return "R4 high64";
            2:       return "R5 high32";
            default: return "R3 low64";
        endcase
    endfunction

    // Random operation of a chosen extension kind.
    task automatic send_kind(int kind, string over);
        int          sel;
        logic [64:0] a, b;
        logic [63:0] x, y;
        x = rnd64();
        y = rnd64();
        case (kind)
            0: begin sel = $urandom % 2; a = sx64(x); b = sx64(y); end
            1: begin sel = $urandom % 2; a = zx64(x); b = zx64(y); end
            2: begin sel = ($urandom % 2) * 2; a = sx32(x[31:0]); b = sx32(y[31:0]); end
            3: begin sel = ($urandom % 2) * 2; a = zx32(x[31:0]); b = zx32(y[31:0]); end
            default: begin sel = 0; a = sx64(x); b = sx16(y[15:0]); end
        endcase
        send(sel, a, b, 1'($urandom), (over != "") ? over : (kind == 0 ? "R2 signed" : sel_req(sel)));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sel = '0; in_dest = '0; in_rec = 1'b0;
        in_a = '0; in_b = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 reset valid", 64'(out_valid), 64'd0);
            chk("R10 reset cr_en", 64'(out_cr_en), 64'd0);
        end
        rst = 1'b0;

        // Directed: positive product, without and with record flag
        send(0, zx64(64'h1000), zx64(64'h1111), 1'b0, "R3 low64");
        idle(DEPTH + 1);
        send(0, zx64(64'h1000), zx64(64'h1111), 1'b1, "R8 positive");
        idle(DEPTH + 1);

        // Corners
        send(0, sx64(64'h8000_0000_0000_0000), sx64(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R2 minneg low");
        send(1, sx64(64'h8000_0000_0000_0000), sx64(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R2 minneg high");
        send(1, zx64(64'h8000_0000_0000_0000), zx64(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R2 unsigned high");
        send(1, zx64(64'hFFFF_FFFF_FFFF_FFFF), zx64(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R4 umax high");
        send(0, sx64(64'h0), sx64(rnd64()), 1'b1, "R8 zero");
        send(2, sx32(32'h8000_0000), sx32(32'h8000_0000), 1'b1, "R5 minneg32");
        send(2, zx32(32'hFFFF_FFFF), zx32(32'hFFFF_FFFF), 1'b1, "R5 umax32");
        send(0, sx64(64'h8000_0000_0000_0000), sx16(16'h8000), 1'b1, "R3 imm minneg");
        send(3, sx64(rnd64()), sx64(rnd64()), 1'b1, "R3 reserved sel");
        idle(DEPTH + 1);

        // Random mix with idle gaps
        for (int k = 0; k < 300; k++) begin
            send_kind(k % 5, "");
            if ($urandom % 3 == 0) idle(1 + $urandom % 3);
        end
        idle(DEPTH + 1);

        // Back-to-back runs
        for (int k = 0; k < 60; k++) send_kind($urandom % 5, "R9 back-to-back");
        idle(DEPTH + 1);

        // Reset with operations in flight
        send_kind(0, "R10 in flight");
        send_kind(1, "R10 in flight");
        send_kind(2, "R10 in flight");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        q.delete();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            chk("R10 flushed", 64'(out_valid), 64'd0);
            @(negedge clk);
        end

        // Pipeline still works after reset
        for (int k = 0; k < 20; k++) send_kind(k % 5, "R9 after reset");
        idle(DEPTH + 2);

        chk("R1 all results seen", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule